// File: doc/BRIEF.md
# Segmented Pointer Update Unit with Segment Carry

This unit keeps two segment:offset pointer pairs for a small 8-bit processor. One pair holds the code segment and instruction pointer, and the other holds the stack segment and stack pointer. Each offset is 8 bits wide, so one segment spans 256 bytes. The unit applies one update per clock to these registers: an instruction-pointer increment, a stack-pointer step up or down, or a relative move that adds a signed 8-bit immediate to a selected register.

Each pair has its own carry-mode flag. While a pair's flag is set, an offset that runs past either edge of its segment carries into, or borrows from, that pair's segment register. The pair then behaves as one 16-bit address. While the flag is clear, the offset wraps inside its segment and the segment register keeps its value. Two commands set and clear these flags, and each command names the pair it affects.

A relative move aimed at any register other than the two pointers is a plain 8-bit add. The unit returns the sum on a separate output, and the pointer state does not change.

Top module: `segCarryUnit`

## Requirements
- R1: While `rstN` is low, all four pointer registers become 0 and both carry-mode flags become 0. The first address after reset is therefore 0:0.
- R2: Opcode 1 increments the instruction pointer by 1. If the pointer goes from 255 to 0 while code carry mode is on, the code segment goes up by 1 on the same edge.
- R3: While code carry mode is off, every instruction-pointer update wraps modulo 256 and leaves the code segment unchanged. The same rule holds for the stack pair while stack carry mode is off.
- R4: Opcode 2 decrements the stack pointer by 1, and opcode 3 increments it by 1. While stack carry mode is on, a wrap from 0 to 255 decrements the stack segment, and a wrap from 255 to 0 increments it.
- R5: Opcode 5 sets a carry-mode flag and opcode 6 clears one. `cmdSel` picks the flag: 0 for the code pair, 1 for the stack pair. The other flag does not change.
- R6: Opcode 4 is the relative move. It adds `relImm`, read as two's complement, to the register picked by `regSel` (0 for the instruction pointer, 1 for the stack pointer). If the target pair's carry mode is on and a positive immediate carries the offset past 255, that pair's segment goes up by 1.
- R7: If a relative move with a negative immediate takes the offset below 0 while the pair's carry mode is on, that pair's segment goes down by 1.
- R8: For a relative move with `regSel` of 2 or more, `genOut` equals `genIn + relImm` modulo 256. No pointer or segment register changes.
- R9: A segment register that is carried past 255 rolls to 0, and one that is borrowed below 0 rolls to 255. There is no other side effect.
- R10: At most one pointer pair is updated per clock. When `cmdValid` is low, or the opcode is 0 or 7, no register and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Opcode (see R2 to R10) |
| cmdSel | input | 1 | Carry-flag select for opcodes 5 and 6 |
| regSel | input | 3 | Target register for the relative move |
| relImm | input | 8 | Signed relative immediate |
| genIn | input | 8 | Value of a general register for the plain add |
| genOut | output | 8 | genIn plus relImm |
| codeSeg | output | 8 | Code segment |
| codeOff | output | 8 | Instruction pointer |
| stackSeg | output | 8 | Stack segment |
| stackOff | output | 8 | Stack pointer |
| codeCarryOn | output | 1 | Code carry mode flag |
| stackCarryOn | output | 1 | Stack carry mode flag |

## Verification
All pointer, segment and flag state is visible at the ports. An error in any of it shows up one clock after the command that caused it. A wrong carry or borrow decision shows at the segment output on the edge where the offset wraps. A lost or crossed carry-mode flag first shows on the flag outputs, then as a missing or unexpected segment change at the next wrap of the affected pair. Comparing every register against a 16-bit address model on every command catches such errors on the cycle they occur.

// File: rtl/segCarryPkg.sv
package segCarryPkg;
  localparam int PTR_W     = 8;
  localparam int REG_SEL_W = 3;
  localparam int NUM_PAIRS = 2;
  localparam int PAIR_CODE  = 0;
  localparam int PAIR_STACK = 1;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_IP_INC    = 3'd1,
    OP_SP_DEC    = 3'd2,
    OP_SP_INC    = 3'd3,
    OP_REL       = 3'd4,
    OP_CARRY_ON  = 3'd5,
    OP_CARRY_OFF = 3'd6,
    OP_RSVD      = 3'd7
  } opE;

  typedef struct packed {
    logic             upd;
    logic [PTR_W-1:0] delta;
    logic             carryEn;
  } pairStrobeT;
endpackage

// File: rtl/segCarryCtrl.sv
module segCarryCtrl
  import segCarryPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cmdValid,
  input  logic [2:0]                       cmdOp,
  input  logic                             cmdSel,
  input  logic [REG_SEL_W-1:0]             regSel,
  input  logic [PTR_W-1:0]                 relImm,
  output pairStrobeT [NUM_PAIRS-1:0]       strobes,
  output logic [NUM_PAIRS-1:0]             carryMode
);
  localparam logic [PTR_W-1:0] ONE   = PTR_W'(1);
  localparam logic [PTR_W-1:0] MINUS = '1;

  opE op;
  assign op = opE'(cmdOp);

  logic setCmd, clrCmd;
  assign setCmd = cmdValid && (op == OP_CARRY_ON);
  assign clrCmd = cmdValid && (op == OP_CARRY_OFF);

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : gMode
    always_ff @(posedge clk) begin
      if (!rstN)
        carryMode[i] <= 1'b0;
      else if (setCmd && (int'(cmdSel) == i))
        carryMode[i] <= 1'b1;
      else if (clrCmd && (int'(cmdSel) == i))
        carryMode[i] <= 1'b0;
    end

    // R5: a flag moves only on a carry command that selects it
    a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
      !((setCmd || clrCmd) && (int'(cmdSel) == i)) |=> $stable(carryMode[i]));
  end

  always_comb begin
    for (int i = 0; i < NUM_PAIRS; i++) begin
      strobes[i].upd     = 1'b0;
      strobes[i].delta   = '0;
      strobes[i].carryEn = carryMode[i];
    end
    if (cmdValid) begin
      unique case (op)
        OP_IP_INC: begin
          strobes[PAIR_CODE].upd   = 1'b1;
          strobes[PAIR_CODE].delta = ONE;
        end
        OP_SP_DEC: begin
          strobes[PAIR_STACK].upd   = 1'b1;
          strobes[PAIR_STACK].delta = MINUS;
        end
        OP_SP_INC: begin
          strobes[PAIR_STACK].upd   = 1'b1;
          strobes[PAIR_STACK].delta = ONE;
        end
        OP_REL: begin
          for (int i = 0; i < NUM_PAIRS; i++) begin
            if (int'(regSel) == i) begin
              strobes[i].upd   = 1'b1;
              strobes[i].delta = relImm;
            end
          end
        end
        default: ;
      endcase
    end
  end

  logic [NUM_PAIRS-1:0] updVec;
  always_comb
    for (int i = 0; i < NUM_PAIRS; i++) updVec[i] = strobes[i].upd;

  // R10: never more than one pair written per clock
  a_r10_single_pair: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updVec));
endmodule

// File: rtl/segPtrPair.sv
module segPtrPair
  import segCarryPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pairStrobeT       strobe,
  output logic [PTR_W-1:0] seg,
  output logic [PTR_W-1:0] off
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W:0] sum;
  logic           negStep, carryOut, segInc, segDec;

  assign sum      = {1'b0, off} + {1'b0, strobe.delta};
  assign negStep  = strobe.delta[PTR_W-1];
  assign carryOut = sum[PTR_W];
  assign segInc   = strobe.carryEn && !negStep && carryOut;
  assign segDec   = strobe.carryEn && negStep && !carryOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      off <= '0;
      seg <= '0;
    end else if (strobe.upd) begin
      off <= sum[PTR_W-1:0];
      if (segInc)      seg <= seg + ONE;
      else if (segDec) seg <= seg - ONE;
    end
  end

  // R3: segment frozen while its carry mode is off
  a_r3_seg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.upd && !strobe.carryEn) |=> $stable(seg));

  // R10: no update, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.upd |=> ($stable(seg) && $stable(off)));

  // R2 / R9: unit step over the top edge carries into the segment
  a_r2_carry_up: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.upd && strobe.carryEn && strobe.delta == ONE && off == '1)
      |=> (off == '0 && seg == PTR_W'($past(seg) + ONE)));

  // R7 / R9: unit step under the bottom edge borrows from the segment
  a_r7_borrow_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.upd && strobe.carryEn && strobe.delta == '1 && off == '0)
      |=> (off == '1 && seg == PTR_W'($past(seg) - ONE)));
endmodule

// File: rtl/segCarryPath.sv
module segCarryPath
  import segCarryPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  pairStrobeT [NUM_PAIRS-1:0]        strobes,
  input  logic [PTR_W-1:0]                  genIn,
  input  logic [PTR_W-1:0]                  relImm,
  output logic [NUM_PAIRS-1:0][PTR_W-1:0]   segs,
  output logic [NUM_PAIRS-1:0][PTR_W-1:0]   offs,
  output logic [PTR_W-1:0]                  genOut
);
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : gPair
    segPtrPair uPair (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[i]),
      .seg    (segs[i]),
      .off    (offs[i])
    );
  end

  assign genOut = genIn + relImm;
endmodule

// File: rtl/segCarryUnit.sv
module segCarryUnit
  import segCarryPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdSel,
  input  logic [2:0]       regSel,
  input  logic [7:0]       relImm,
  input  logic [7:0]       genIn,
  output logic [7:0]       genOut,
  output logic [7:0]       codeSeg,
  output logic [7:0]       codeOff,
  output logic [7:0]       stackSeg,
  output logic [7:0]       stackOff,
  output logic             codeCarryOn,
  output logic             stackCarryOn
);
  pairStrobeT [NUM_PAIRS-1:0]      strobes;
  logic [NUM_PAIRS-1:0]            carryMode;
  logic [NUM_PAIRS-1:0][PTR_W-1:0] segs, offs;

  segCarryCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdSel    (cmdSel),
    .regSel    (regSel),
    .relImm    (relImm),
    .strobes   (strobes),
    .carryMode (carryMode)
  );

  segCarryPath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .genIn   (genIn),
    .relImm  (relImm),
    .segs    (segs),
    .offs    (offs),
    .genOut  (genOut)
  );

  assign codeSeg      = segs[PAIR_CODE];
  assign codeOff      = offs[PAIR_CODE];
  assign stackSeg     = segs[PAIR_STACK];
  assign stackOff     = offs[PAIR_STACK];
  assign codeCarryOn  = carryMode[PAIR_CODE];
  assign stackCarryOn = carryMode[PAIR_STACK];

  // R1: reset leaves everything at zero on the next edge
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (codeSeg == 0 && codeOff == 0 && stackSeg == 0 && stackOff == 0
               && !codeCarryOn && !stackCarryOn));
endmodule

// File: tb/segCarryUnit_test.sv
module segCarryUnit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic       cmdSel = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [7:0] relImm = 8'd0;
  logic [7:0] genIn = 8'd0;
  logic [7:0] genOut, codeSeg, codeOff, stackSeg, stackOff;
  logic       codeCarryOn, stackCarryOn;

  int total = 0;
  int bad   = 0;
  int cs = 0, ip = 0, ss = 0, sp = 0, ce = 0, se = 0;

  always #10 clk = ~clk;

  segCarryUnit uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSel(cmdSel), .regSel(regSel), .relImm(relImm), .genIn(genIn),
    .genOut(genOut), .codeSeg(codeSeg), .codeOff(codeOff),
    .stackSeg(stackSeg), .stackOff(stackOff),
    .codeCarryOn(codeCarryOn), .stackCarryOn(stackCarryOn)
  );

  task automatic stepPair(inout int seg, inout int off, input int en, input int d);
    int a;
    if (en != 0) begin
      a = (seg * 256 + off + d + 65536) % 65536;
      seg = a / 256;
      off = a % 256;
    end else begin
      off = (off + d + 256) % 256;
    end
  endtask

  task automatic checkState(input string tag);
    total++;
    if (codeSeg != cs[7:0] || codeOff != ip[7:0] || stackSeg != ss[7:0] ||
        stackOff != sp[7:0] || codeCarryOn != ce[0] || stackCarryOn != se[0]) begin
      bad++;
      $display("FAIL %s: actual cs=%0d ip=%0d ss=%0d sp=%0d ce=%0d se=%0d expected cs=%0d ip=%0d ss=%0d sp=%0d ce=%0d se=%0d",
               tag, codeSeg, codeOff, stackSeg, stackOff, codeCarryOn, stackCarryOn,
               cs, ip, ss, sp, ce, se);
    end
  endtask

  task automatic doCmd(input bit v, input int op, input int sel, input int rs,
                       input int imm, input int gen, input string tag);
    int d;
    @(negedge clk);
    cmdValid = v; cmdOp = op[2:0]; cmdSel = sel[0]; regSel = rs[2:0];
    relImm = imm[7:0]; genIn = gen[7:0];
    #1;
    if (v && op == 4 && rs >= 2) begin
      total++;
      if (genOut != 8'((gen + imm) % 256)) begin
        bad++;
        $display("FAIL R8: actual genOut=%0d expected %0d", genOut, (gen + imm) % 256);
      end
    end
    d = (imm >= 128) ? imm - 256 : imm;
    if (v) begin
      case (op)
        1: stepPair(cs, ip, ce, 1);
        2: stepPair(ss, sp, se, -1);
        3: stepPair(ss, sp, se, 1);
        4: if (rs == 0) stepPair(cs, ip, ce, d);
           else if (rs == 1) stepPair(ss, sp, se, d);
        5: if (sel == 0) ce = 1; else se = 1;
        6: if (sel == 0) ce = 0; else se = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    checkState(tag);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checkState("R1");
    @(negedge clk);
    rstN = 1'b1;
    // R5 enable code carry only
    doCmd(1, 5, 0, 0, 0, 0, "R5");
    // R6 relative positive without overflow
    doCmd(1, 4, 0, 0, 127, 0, "R6");
    doCmd(1, 4, 0, 0, 127, 0, "R6");
    // R2 increment across the top edge
    doCmd(1, 1, 0, 0, 0, 0, "R2");
    doCmd(1, 1, 0, 0, 0, 0, "R2");
    // R3 carry off: wrap below 0 keeps segment
    doCmd(1, 6, 0, 0, 0, 0, "R5");
    doCmd(1, 4, 0, 0, 255, 0, "R3");
    doCmd(1, 1, 0, 0, 0, 0, "R3");
    doCmd(1, 4, 0, 0, 255, 0, "R3");
    // R6 carry on: +1 over top
    doCmd(1, 5, 0, 0, 0, 0, "R5");
    doCmd(1, 4, 0, 0, 1, 0, "R6");
    // R7 negative immediate borrows
    doCmd(1, 4, 0, 0, 254, 0, "R7");
    doCmd(1, 4, 0, 0, 128, 0, "R7");
    // R4 stack steps, carry off then on
    doCmd(1, 2, 0, 0, 0, 0, "R4");
    doCmd(1, 5, 1, 0, 0, 0, "R5");
    doCmd(1, 3, 0, 0, 0, 0, "R4");
    doCmd(1, 2, 0, 0, 0, 0, "R4");
    // R9 segment rolls over
    doCmd(1, 6, 1, 0, 0, 0, "R5");
    doCmd(1, 3, 0, 0, 0, 0, "R3");
    doCmd(1, 5, 1, 0, 0, 0, "R5");
    doCmd(1, 2, 0, 0, 0, 0, "R9");
    doCmd(1, 3, 0, 0, 0, 0, "R9");
    doCmd(1, 4, 0, 1, 128, 0, "R7");
    // R8 general register adds
    doCmd(1, 4, 0, 3, 5, 250, "R8");
    doCmd(1, 4, 0, 2, 250, 3, "R8");
    doCmd(1, 4, 0, 7, 200, 100, "R8");
    // R10 idle and reserved opcodes
    doCmd(0, 1, 0, 0, 0, 0, "R10");
    doCmd(0, 5, 1, 0, 0, 0, "R10");
    doCmd(1, 7, 0, 0, 9, 0, "R10");
    doCmd(1, 0, 0, 0, 9, 0, "R10");
    // R10 mixed random stream against the model
    for (int n = 0; n < 400; n++) begin
      doCmd(($urandom % 10) != 0, int'($urandom % 8), int'($urandom % 2),
            int'($urandom % 4), int'($urandom % 256), int'($urandom % 256), "R10");
    end
    // R1 reset again from a dirty state
    @(negedge clk);
    rstN = 1'b0;
    cmdValid = 1'b0;
    cs = 0; ip = 0; ss = 0; sp = 0; ce = 0; se = 0;
    @(posedge clk);
    #2;
    checkState("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule